// File: doc/BRIEF.md
# ADC Power-Up Probe and Register-Access Controller

This block sits between a host and an external successive-approximation converter during the device's configuration phase. After system reset it forces the converter through a power-down/reset cycle. It then confirms that the device is present by watching for the ready pulse the device emits once the reset line is released. A host can request the same probe again at any time.

Once the device has answered, the host writes and reads the converter's registers with a single strobe. Each strobe carries an opcode, an address and write data. The block turns the request into SPI frames. For a read, it waits for the device to raise READY before clocking back the one-byte answer. The conversion-start line is held high for the whole phase.

The controller is one state machine with eight named states:

- `ST_PD_HOLD` keeps the reset line low.
- `ST_WAIT_HI` waits for the ready pulse to start.
- `ST_WAIT_LO` waits for the ready pulse to end.
- `ST_IDLE` accepts commands.
- `ST_WR_FRM` sends a write frame.
- `ST_RD_CMD` sends a read-command frame.
- `ST_RD_WAIT` waits for READY.
- `ST_RD_BYTE` clocks the answer byte.

Its transitions are:

- Reset enters `ST_PD_HOLD`.
- Hold expiry moves to `ST_WAIT_HI`.
- READY high moves to `ST_WAIT_LO`.
- READY low moves to `ST_IDLE`.
- A write, read or probe strobe in `ST_IDLE` moves to `ST_WR_FRM`, `ST_RD_CMD` or `ST_PD_HOLD`.
- Frame end moves back to `ST_IDLE`, or from `ST_RD_CMD` to `ST_RD_WAIT`.
- READY high moves `ST_RD_WAIT` to `ST_RD_BYTE`.
- A timeout in any waiting state returns to `ST_IDLE` with the error flag set.

Top module: `adc_cfg_ctrl`

## Requirements
- R1: After system reset, and after an accepted probe command (cmd_op = 2), pd_n is driven low for HOLD_CYC clock cycles and then released high. Busy is high throughout.
- R2: After pd_n rises, the block waits for the synchronised READY to go high and then low again. It then returns to idle with busy low and err clear.
- R3: If READY does not rise within TMO_CYC cycles of pd_n rising, or stays high for TMO_CYC cycles, err is set and busy drops in the same cycle.
- R4: cnv is high at all times, including during reset, probing and register access.
- R5: A write command (cmd_op = 0) sends one 16-bit frame with cs_n held low: bits [15:12] = 4'hC, bits [11:8] = address, bits [7:0] = write data.
- R6: A read command (cmd_op = 1) first sends a 16-bit frame: bits [15:12] = 4'h3, bits [11:8] = address, bits [7:0] = 0. It then raises cs_n, waits for READY high, and runs an 8-bit frame that captures miso MSB first into rd_data.
- R7: rd_valid is a single-cycle pulse that marks a new rd_data, issued when the read-back frame ends.
- R8: SPI is mode 0. sclk idles low and only toggles while cs_n is low, each sclk phase lasts SCLK_HALF cycles, mosi is sent MSB first, and miso is sampled on the rising sclk edge.
- R9: busy rises the cycle after an accepted strobe and falls when the final frame ends. Strobes while busy, and strobes with cmd_op = 3, are ignored and produce no frame.
- R10: If READY does not rise within TMO_CYC cycles after a read-command frame, err is set, no read-back frame is run and no rd_valid is given.
- R11: cs_n is high whenever pd_n is low.
- R12: err is cleared when a probe starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous-deassert reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 write, 1 read, 2 probe, 3 ignored |
| cmd_addr | input | 4 | Register address |
| cmd_wdata | input | 8 | Write data |
| rd_data | output | 8 | Last byte read back |
| rd_valid | output | 1 | One-cycle pulse marking new rd_data |
| busy | output | 1 | Command or probe in progress |
| err | output | 1 | Ready timeout seen since the last probe start |
| pd_n | output | 1 | Active-low power-down/reset to the converter |
| cnv | output | 1 | Conversion-start line, held high |
| cs_n | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to the device |
| ready | input | 1 | Device READY line, asynchronous |
| miso | input | 1 | Device serial data out |

## Verification
The bench builds the block with HOLD_CYC = 100, TMO_CYC = 300 and SCLK_HALF = 2, so that a 90-cycle ready pulse and slow read answers of 20 or 400 cycles fall on either side of the timeout. These small values make probe success, an absent device, a late read answer and recovery by a fresh probe all reachable in a few thousand cycles. Alongside the converter model that captures every frame, this exposes the hold length, the frame contents and the ignore rule at the pins.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        ST_PD_HOLD,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_IDLE,
        ST_WR_FRM,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_RD_BYTE
    } ctl_state_e;

    localparam logic [1:0] HOP_WRITE = 2'd0;
    localparam logic [1:0] HOP_READ  = 2'd1;
    localparam logic [1:0] HOP_PROBE = 2'd2;

    localparam int         OPC_W  = 4;
    localparam int         DATA_W = 8;
    localparam logic [3:0] DEV_WR = 4'hC;
    localparam logic [3:0] DEV_RD = 4'h3;

endpackage

// File: rtl/acc_sync.sv
module acc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/acc_timer.sv
module acc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (clear)            count <= '0;
        else if (count != {W{1'b1}}) count <= count + 1'b1;
    end
endmodule

// File: rtl/acc_spi_shift.sv
module acc_spi_shift #(
    parameter int FRAME_W   = 16,
    parameter int RX_W      = 8,
    parameter int SCLK_HALF = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(FRAME_W+1)-1:0] nbits,
    input  logic [FRAME_W-1:0]           word,
    input  logic                         miso,
    output logic                         cs_n,
    output logic                         sclk,
    output logic                         mosi,
    output logic [RX_W-1:0]              rx,
    output logic                         done
);
    localparam int PH_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int NB_W = $clog2(FRAME_W+1);

    logic               active, tail;
    logic [PH_W-1:0]    ph;
    logic [NB_W-1:0]    bitc;
    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            tail   <= 1'b0;
            ph     <= '0;
            bitc   <= '0;
            sh     <= '0;
            rx     <= '0;
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                tail   <= 1'b0;
                cs_n   <= 1'b0;
                sclk   <= 1'b0;
                sh     <= word;
                bitc   <= '0;
                ph     <= '0;
            end else if (active) begin
                if (ph == PH_W'(SCLK_HALF-1)) begin
                    ph <= '0;
                    if (tail) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                    end else if (!sclk) begin
                        sclk <= 1'b1;
                        rx   <= {rx[RX_W-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitc == nbits - 1'b1) begin
                            tail <= 1'b1;
                        end else begin
                            bitc <= bitc + 1'b1;
                            sh   <= {sh[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    assign mosi = active ? sh[FRAME_W-1] : 1'b0;
endmodule

// File: rtl/adc_cfg_ctrl.sv
module adc_cfg_ctrl
    import acc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int HOLD_CYC  = 100000,
    parameter int TMO_CYC   = 200000,
    parameter int SCLK_HALF = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              err,
    output logic              pd_n,
    output logic              cnv,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              ready,
    input  logic              miso
);
    localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
    localparam int NB_W    = $clog2(FRAME_W+1);
    localparam int MAXC    = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
    localparam int TW      = $clog2(MAXC+1) + 1;

    ctl_state_e state_q, state_d;

    logic               rdy_s;
    logic [TW-1:0]      cnt;
    logic               tmr_clr, hold_end, tmo;
    logic               accept, fail, spi_start, spi_done;
    logic [NB_W-1:0]    spi_nbits;
    logic [FRAME_W-1:0] spi_word;
    logic [DATA_W-1:0]  spi_rx;

    acc_sync #(.STAGES(SYNC_STG)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d(ready), .q(rdy_s)
    );

    acc_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .count(cnt)
    );

    acc_spi_shift #(
        .FRAME_W(FRAME_W), .RX_W(DATA_W), .SCLK_HALF(SCLK_HALF)
    ) u_spi (
        .clk(clk), .rst_n(rst_n), .start(spi_start), .nbits(spi_nbits),
        .word(spi_word), .miso(miso), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .rx(spi_rx), .done(spi_done)
    );

    assign hold_end = (cnt == TW'(HOLD_CYC-1));
    assign tmo      = (cnt == TW'(TMO_CYC-1));
    assign accept   = (state_q == ST_IDLE) && cmd_valid && (cmd_op != 2'd3);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PD_HOLD;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PD_HOLD: if (hold_end) state_d = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (rdy_s)    state_d = ST_WAIT_LO;
                else if (tmo) state_d = ST_IDLE;
            end
            ST_WAIT_LO: begin
                if (!rdy_s)   state_d = ST_IDLE;
                else if (tmo) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_op)
                        HOP_WRITE: state_d = ST_WR_FRM;
                        HOP_READ:  state_d = ST_RD_CMD;
                        HOP_PROBE: state_d = ST_PD_HOLD;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WR_FRM:  if (spi_done) state_d = ST_IDLE;
            ST_RD_CMD:  if (spi_done) state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (rdy_s)    state_d = ST_RD_BYTE;
                else if (tmo) state_d = ST_IDLE;
            end
            ST_RD_BYTE: if (spi_done) state_d = ST_IDLE;
            default:    state_d = ST_PD_HOLD;
        endcase
    end

    // state-derived outputs and strobes
    always_comb begin
        busy      = (state_q != ST_IDLE);
        pd_n      = (state_q != ST_PD_HOLD);
        cnv       = 1'b1;
        tmr_clr   = (state_d != state_q);
        spi_start = tmr_clr && ((state_d == ST_WR_FRM) || (state_d == ST_RD_CMD) ||
                                (state_d == ST_RD_BYTE));
        spi_nbits = (state_d == ST_RD_BYTE) ? NB_W'(DATA_W) : NB_W'(FRAME_W);
        if (state_q == ST_IDLE)
            spi_word = {(cmd_op == HOP_READ) ? DEV_RD : DEV_WR, cmd_addr,
                        (cmd_op == HOP_READ) ? {DATA_W{1'b0}} : cmd_wdata};
        else
            spi_word = '0;
        fail = ((state_q == ST_WAIT_HI) && !rdy_s && tmo) ||
               ((state_q == ST_WAIT_LO) &&  rdy_s && tmo) ||
               ((state_q == ST_RD_WAIT) && !rdy_s && tmo);
    end

    // result and error registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if ((state_q == ST_RD_BYTE) && spi_done) begin
                rd_data  <= spi_rx;
                rd_valid <= 1'b1;
            end
            if (fail)
                err <= 1'b1;
            else if ((state_d == ST_PD_HOLD) && (state_q != ST_PD_HOLD))
                err <= 1'b0;
        end
    end
endmodule

// File: rtl/acc_cfg_checker.sv
module acc_cfg_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic err,
    input logic rd_valid,
    input logic pd_n,
    input logic cnv,
    input logic cs_n,
    input logic sclk
);
    assert_pd_cs_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> cs_n);

    assert_sclk_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    assert_rdv_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rdv_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy && cs_n);

    assert_err_drops_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    assert_release_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_n) |-> busy);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && !sclk && cs_n && !pd_n) |=> busy);

    assert_cnv_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_n) |-> cnv);

    assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_n) |=> !err);
endmodule

bind adc_cfg_ctrl acc_cfg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .err(err),
    .rd_valid(rd_valid), .pd_n(pd_n), .cnv(cnv), .cs_n(cs_n), .sclk(sclk)
);

// File: tb/sim_adc_cfg_ctrl.sv
module sim_adc_cfg_ctrl;
    localparam int HOLD  = 100;
    localparam int TMO   = 300;
    localparam int HALF  = 2;
    localparam int PULSE = 90;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic [7:0] rd_data;
    logic       rd_valid, busy, err, pd_n, cnv, cs_n, sclk, mosi;
    logic       ready = 1'b0;
    logic       miso = 1'b0;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    adc_cfg_ctrl #(
        .ADDR_W(4), .HOLD_CYC(HOLD), .TMO_CYC(TMO), .SCLK_HALF(HALF), .SYNC_STG(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .err(err), .pd_n(pd_n), .cnv(cnv),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .ready(ready), .miso(miso)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    bit        present  = 1'b1;
    int        rd_delay = 20;
    logic [7:0] dev_regs [16];
    logic      in_frame = 1'b0;
    logic      resp_mode = 1'b0;
    logic [7:0] resp = 8'd0;
    logic [15:0] cap = 16'd0;
    int        capn = 0;

    initial for (int i = 0; i < 16; i++) dev_regs[i] = 8'h00;

    always @(negedge pd_n) begin
        ready     = 1'b0;
        resp_mode = 1'b0;
    end

    always @(posedge pd_n) begin
        if (present) begin
            fork
                begin
                    repeat (5) @(posedge clk);
                    ready = 1'b1;
                    repeat (PULSE) @(posedge clk);
                    ready = 1'b0;
                end
            join_none
        end
    end

    always @(negedge cs_n) begin
        in_frame = 1'b1;
        cap  = 16'd0;
        capn = 0;
        if (resp_mode) begin
            miso  = resp[7];
            ready = 1'b0;
        end else begin
            miso = 1'b0;
        end
    end

    always @(posedge sclk) if (!cs_n) begin
        cap  = {cap[14:0], mosi};
        capn = capn + 1;
    end

    always @(negedge sclk) if (!cs_n && resp_mode) begin
        resp = {resp[6:0], 1'b0};
        miso = resp[7];
    end

    // ---------------- scoreboard ----------------
    logic [20:0] exp_frames [$];
    logic [7:0]  exp_rd [$];
    logic [7:0]  shadow [16];
    initial for (int i = 0; i < 16; i++) shadow[i] = 8'h00;

    always @(posedge cs_n) if (in_frame) begin
        logic [20:0] item;
        in_frame = 1'b0;
        if (exp_frames.size() == 0) begin
            check("R9 unexpected frame", {11'd0, capn[4:0], cap}, 32'h0);
        end else begin
            item = exp_frames.pop_front();
            check("R5/R6/R8 frame", {11'd0, capn[4:0], cap}, {11'd0, item});
        end
        if (resp_mode) begin
            resp_mode = 1'b0;
        end else if (capn == 16 && cap[15:12] == 4'hC) begin
            dev_regs[cap[11:8]] = cap[7:0];
        end else if (capn == 16 && cap[15:12] == 4'h3) begin
            fork
                begin
                    logic [3:0] a;
                    int d;
                    a = cap[11:8];
                    d = rd_delay;
                    repeat (d) @(posedge clk);
                    if (pd_n) begin
                        resp      = dev_regs[a];
                        resp_mode = 1'b1;
                        ready     = 1'b1;
                    end
                end
            join_none
        end
    end

    // rd_valid monitor (R6, R7)
    logic rdv_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid && rdv_prev) check("R7 rd_valid longer than one cycle", 32'd1, 32'd0);
            if (rd_valid) begin
                if (exp_rd.size() == 0) check("R10 unexpected rd_valid", {24'd0, rd_data}, 32'hFFFF);
                else check("R6 rd_data", {24'd0, rd_data}, {24'd0, exp_rd.pop_front()});
            end
        end
        rdv_prev = rd_valid;
    end

    // continuous pin monitors (R4, R8, R11, R1)
    int  cnv_bad = 0, cs_bad = 0, sclk_bad = 0, hi_len = 0, pd_len = 0;
    always @(negedge clk) begin
        cycles++;
        if (cnv !== 1'b1) cnv_bad++;
        if (rst_n && !pd_n && cs_n !== 1'b1) cs_bad++;
        if (rst_n && cs_n && sclk !== 1'b0) sclk_bad++;
        if (sclk) hi_len++;
        if (rst_n && !pd_n) pd_len++;
    end

    always @(negedge sclk) if (rst_n) begin
        check("R8 sclk high phase", hi_len, HALF);
        hi_len = 0;
    end

    always @(posedge pd_n) if (rst_n) begin
        vectors++;
        if (pd_len < HOLD || pd_len > HOLD + 1) begin
            errors++;
            $display("FAIL R1: pd_n low for %0d expected %0d", pd_len, HOLD);
        end
        pd_len = 0;
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // ---------------- driver ----------------
    task automatic strobe(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        exp_frames.push_back({5'd16, 4'hC, a, d});
        shadow[a] = d;
        strobe(2'd0, a, d);
        wait_idle();
    endtask

    task automatic do_read(input logic [3:0] a, input bit answer);
        exp_frames.push_back({5'd16, 4'h3, a, 8'h00});
        if (answer) begin
            exp_frames.push_back({5'd8, 16'h0000});
            exp_rd.push_back(shadow[a]);
        end
        strobe(2'd1, a, 8'h00);
        wait_idle();
    endtask

    task automatic do_probe();
        strobe(2'd2, 4'd0, 8'd0);
        wait_idle();
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        check("R1 reset pd_n", pd_n, 1'b0);
        check("R4 reset cnv", cnv, 1'b1);
        check("R11 reset cs_n", cs_n, 1'b1);
        check("R8 reset sclk", sclk, 1'b0);
        check("R9 reset busy", busy, 1'b1);
        check("R3 reset err", err, 1'b0);
        check("R7 reset rd_valid", rd_valid, 1'b0);
        rst_n = 1'b1;
        t0 = cycles;
        wait_idle();
        check("R2 probe ok err", err, 1'b0);
        check("R2 probe waited for pulse", (cycles - t0) >= HOLD + PULSE, 1'b1);

        do_write(4'd1, 8'hA5);
        do_write(4'd2, 8'h3C);
        do_write(4'd15, 8'hFF);
        do_write(4'd0, 8'h81);
        do_read(4'd1, 1'b1);
        do_read(4'd2, 1'b1);
        do_read(4'd15, 1'b1);
        do_read(4'd0, 1'b1);
        do_read(4'd7, 1'b1);

        // R9: strobe while busy is ignored
        exp_frames.push_back({5'd16, 4'hC, 4'd3, 8'h5A});
        shadow[3] = 8'h5A;
        strobe(2'd0, 4'd3, 8'h5A);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = 4'd9;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        repeat (60) @(negedge clk);
        check("R9 ignored strobe left no pending frame", exp_frames.size(), 0);
        check("R9 ignored strobe busy", busy, 1'b0);
        // R9: opcode 3 ignored
        strobe(2'd3, 4'd3, 8'h00);
        check("R9 op3 busy", busy, 1'b0);
        repeat (40) @(negedge clk);
        do_read(4'd3, 1'b1);

        // R10: late read answer
        rd_delay = 400;
        do_read(4'd2, 1'b0);
        check("R10 err after read timeout", err, 1'b1);
        check("R10 busy after read timeout", busy, 1'b0);
        check("R10 no rd answer pending", exp_rd.size(), 0);
        repeat (200) @(negedge clk);
        rd_delay = 20;

        // R12: probe clears error
        do_probe();
        check("R12 err cleared by probe", err, 1'b0);
        do_read(4'd2, 1'b1);

        // R3: absent device
        present = 1'b0;
        t0 = cycles;
        do_probe();
        check("R3 err absent", err, 1'b1);
        check("R3 timeout length", (cycles - t0) >= HOLD + TMO, 1'b1);
        present = 1'b1;
        do_probe();
        check("R12 err after recovery", err, 1'b0);
        do_write(4'd4, 8'h6E);
        do_read(4'd4, 1'b1);
        repeat (50) @(negedge clk);

        check("R5 frames all seen", exp_frames.size(), 0);
        check("R7 rd answers all seen", exp_rd.size(), 0);
        check("R4 cnv low cycles", cnv_bad, 0);
        check("R11 cs_n low during power-down", cs_bad, 0);
        check("R8 sclk outside frame", sclk_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule